// File: doc/BRIEF.md
# Indirect Block Transfer Controller for Character Peripherals

This controller moves blocks of 24-bit words between a shared word memory and one of several character-wide peripheral channels. It is set up indirectly. The processor issues a start command that carries a pointer word, and the low 12 bits of that word give the address Y of a three-word control block in memory. The controller reads the block from Y, Y+1 and Y+2, in that order. The block holds the command, the number of words and the first data address.

After the fetch, the controller sends the device number and the operation code to the selected channel as two characters. It then streams the data. In output mode each memory word becomes four 6-bit characters on the transmit side. In input mode every four received characters are packed into one word and written to memory. Each character travels with an odd-parity bit.

At the end of an operation the controller writes a 12-bit completion code, together with the original Y, into a fixed pointer location in memory. It then pulses an interrupt, but only if interrupts were enabled earlier. An abort command cuts an operation short. A channel select that is sampled at start decides which single channel is active for the operation.

Top module: `xfer_ctrl`

## Requirements
- R1: A start pulse while idle latches Y from pointer bits 11..0 and the channel select. The controller then reads memory at Y, Y+1 and Y+2, in that order, before any character leaves on a channel.
- R2: Command word bits 11..6 hold the device number and bits 5..0 hold the operation code. The two are sent as two characters, device first. Opcode bit 5 = 1 selects input (channel to memory) and 0 selects output.
- R3: The word count comes from bits 15..0 of the word at Y+1 and the first data address from bits 15..0 of the word at Y+2. Bits 23..16 of both words, and bits 23..12 of the command word, have no effect.
- R4: In output mode, words are read from consecutive addresses. Each word is sent as four characters: bits 23..18 first, then 17..12, 11..6 and 5..0.
- R5: In input mode, four received characters form one word. The first character received lands in bits 23..18. Words are written to consecutive addresses.
- R6: Every transmitted character carries a parity bit that makes the total count of ones odd. A received character whose total count of ones is even sets status bit 0. The character is still stored.
- R7: A memory request stays asserted, with stable address and direction, until it is granted. A transfer takes place in the cycle where request and grant are both high.
- R8: Only the channel latched at start shows valid or ready activity. A select value of NCH or more sets status bit 3 and moves no characters or data.
- R9: At completion the controller writes {status[11:0], Y} to PTR_ADDR. Status bit 0 is parity error, bit 1 is abort, bit 2 is zero count and bit 3 is invalid channel. All other status bits are 0.
- R10: busy_o rises in the cycle after an accepted start. It falls in the cycle after the status write is granted, and irq_o pulses for that one cycle when interrupts are enabled.
- R11: An activate-interrupt pulse enables the interrupt until reset. Before that pulse, operations complete without an interrupt.
- R12: An abort while busy, before the status write, ends the operation, sets status bit 1 and goes to the status write. An abort while idle has no effect.
- R13: A word count of zero still sends the two command characters. It then moves no data and sets status bit 2.
- R14: A start pulse while busy is ignored. The running operation finishes unchanged and no second operation follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start command pulse |
| start_ptr_i | input | 24 | Pointer word carried by the start command |
| chan_sel_i | input | 2 | Channel select, sampled at start |
| abort_i | input | 1 | Abort command pulse |
| act_int_i | input | 1 | Interrupt enable command pulse |
| busy_o | output | 1 | Operation in progress |
| irq_o | output | 1 | Ready interrupt pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write when high, read when low |
| mem_addr_o | output | 16 | Memory word address |
| mem_wdata_o | output | 24 | Memory write data |
| mem_gnt_i | input | 1 | Memory grant |
| mem_rdata_i | input | 24 | Memory read data, valid in the grant cycle |
| tx_valid_o | output | NCH | Per-channel transmit valid |
| tx_char_o | output | 6*NCH | Per-channel transmit character |
| tx_par_o | output | NCH | Per-channel transmit parity |
| tx_ready_i | input | NCH | Per-channel transmit ready |
| rx_valid_i | input | NCH | Per-channel receive valid |
| rx_char_i | input | 6*NCH | Per-channel receive character |
| rx_par_i | input | NCH | Per-channel receive parity |
| rx_ready_o | output | NCH | Per-channel receive ready |

## Verification
The hardest situations to reach are an abort in the middle of a character stream and a second start that arrives while an operation is running. Both depend on how far the transfer has progressed, and that in turn depends on random grant and ready stalls. The bench therefore triggers them from progress it observes at the ports, either the number of characters logged or the number consumed from its receive source, rather than at fixed cycle times. A pseudo-random stall pattern on the memory grant and on channel readiness keeps the request-hold and valid-hold rules under pressure throughout a sweep over every channel, both directions and word counts from zero to three.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int WORD_W  = 24;
    localparam int ADDR_W  = 16;
    localparam int CHAR_W  = 6;
    localparam int CPW     = WORD_W / CHAR_W;
    localparam int CIDX_W  = $clog2(CPW);
    localparam int SEL_W   = 2;
    localparam int PTR_Y_W = 12;
    localparam int STAT_W  = 12;
    localparam int CMD_W   = 2 * CHAR_W;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_CMD, S_RDW, S_TX, S_RX, S_WRW, S_STAT
    } state_e;

    typedef struct packed {
        logic inv_chan;
        logic zero_cnt;
        logic aborted;
        logic par_err;
    } flags_t;

    function automatic logic odd_par(input logic [CHAR_W-1:0] c);
        return ~(^c);
    endfunction

    function automatic logic [STAT_W-1:0] pack_status(input flags_t f);
        return {{(STAT_W-4){1'b0}}, f};
    endfunction
endpackage

// File: rtl/xfer_chan_mux.sv
module xfer_chan_mux
    import xfer_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic                  en_i,
    input  logic                  tx_valid_i,
    input  logic [CHAR_W-1:0]     tx_char_i,
    output logic                  tx_ready_o,
    input  logic                  rx_ready_i,
    output logic                  rx_valid_o,
    output logic [CHAR_W-1:0]     rx_char_o,
    output logic                  rx_perr_o,
    output logic [NCH-1:0]        ch_tx_valid_o,
    output logic [NCH*CHAR_W-1:0] ch_tx_char_o,
    output logic [NCH-1:0]        ch_tx_par_o,
    input  logic [NCH-1:0]        ch_tx_ready_i,
    input  logic [NCH-1:0]        ch_rx_valid_i,
    input  logic [NCH*CHAR_W-1:0] ch_rx_char_i,
    input  logic [NCH-1:0]        ch_rx_par_i,
    output logic [NCH-1:0]        ch_rx_ready_o
);
    logic rx_par_sel;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        wire hit = en_i && (sel_i == SEL_W'(g));
        assign ch_tx_valid_o[g]                 = hit && tx_valid_i;
        assign ch_tx_char_o[g*CHAR_W +: CHAR_W] = tx_char_i;
        assign ch_tx_par_o[g]                   = odd_par(tx_char_i);
        assign ch_rx_ready_o[g]                 = hit && rx_ready_i;

        // R6: every character offered to a channel has odd total ones
        a_r6_tx_odd: assert property (@(posedge clk) disable iff (rst)
            ch_tx_valid_o[g] |-> (^{ch_tx_char_o[g*CHAR_W +: CHAR_W], ch_tx_par_o[g]}));
    end

    always_comb begin
        tx_ready_o = 1'b0;
        rx_valid_o = 1'b0;
        rx_char_o  = '0;
        rx_par_sel = 1'b1;
        for (int i = 0; i < NCH; i++) begin
            if (en_i && sel_i == SEL_W'(i)) begin
                tx_ready_o = ch_tx_ready_i[i];
                rx_valid_o = ch_rx_valid_i[i];
                rx_char_o  = ch_rx_char_i[i*CHAR_W +: CHAR_W];
                rx_par_sel = ch_rx_par_i[i];
            end
        end
    end

    assign rx_perr_o = ~(^{rx_char_o, rx_par_sel});

    // R8: at most one channel is driven in any cycle
    a_r8_one_channel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_tx_valid_o) && $onehot0(ch_rx_ready_o));
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_pkg::*;
#(
    parameter int                NCH      = 4,
    parameter logic [ADDR_W-1:0] PTR_ADDR = 16'h0019
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [WORD_W-1:0]  start_ptr_i,
    input  logic [SEL_W-1:0]   chan_sel_i,
    input  logic               abort_i,
    input  logic               act_int_i,
    output logic               busy_o,
    output logic               irq_o,
    output logic               mem_req_o,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [WORD_W-1:0]  mem_wdata_o,
    input  logic               mem_gnt_i,
    input  logic [WORD_W-1:0]  mem_rdata_i,
    output logic [SEL_W-1:0]   sel_o,
    output logic               chan_en_o,
    output logic               tx_valid_o,
    output logic [CHAR_W-1:0]  tx_char_o,
    input  logic               tx_ready_i,
    input  logic               rx_valid_i,
    input  logic [CHAR_W-1:0]  rx_char_i,
    input  logic               rx_perr_i,
    output logic               rx_ready_o
);
    localparam logic [CIDX_W-1:0] CIDX_LAST = CIDX_W'(CPW - 1);

    state_e              st;
    logic [PTR_Y_W-1:0]  ptr_y;
    logic [CMD_W-1:0]    cmd;
    logic [ADDR_W-1:0]   cnt, addr;
    logic [1:0]          fidx;
    logic [CIDX_W-1:0]   cidx;
    logic [WORD_W-1:0]   shreg;
    flags_t              flg;
    logic [SEL_W-1:0]    sel;
    logic                int_en, irq;

    wire unused_hi = ^{mem_rdata_i[WORD_W-1:ADDR_W], start_ptr_i[WORD_W-1:PTR_Y_W]};
    wire dir_in    = cmd[CHAR_W-1];
    wire mem_fire  = mem_req_o && mem_gnt_i;
    wire tx_fire   = tx_valid_o && tx_ready_i;
    wire rx_fire   = rx_ready_o && rx_valid_i;

    always_comb begin
        mem_req_o   = (st == S_FETCH) || (st == S_RDW) || (st == S_WRW) || (st == S_STAT);
        mem_we_o    = (st == S_WRW) || (st == S_STAT);
        case (st)
            S_FETCH: mem_addr_o = ADDR_W'(ptr_y) + ADDR_W'(fidx);
            S_STAT:  mem_addr_o = PTR_ADDR;
            default: mem_addr_o = addr;
        endcase
        mem_wdata_o = (st == S_STAT) ? {pack_status(flg), ptr_y} : shreg;
        tx_valid_o  = (st == S_CMD) || (st == S_TX);
        if (st == S_CMD)
            tx_char_o = cidx[0] ? cmd[CHAR_W-1:0] : cmd[CMD_W-1:CHAR_W];
        else
            tx_char_o = shreg[WORD_W-1 -: CHAR_W];
        rx_ready_o  = (st == S_RX);
    end

    assign busy_o    = (st != S_IDLE);
    assign irq_o     = irq;
    assign sel_o     = sel;
    assign chan_en_o = !flg.inv_chan;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            ptr_y  <= '0;
            cmd    <= '0;
            cnt    <= '0;
            addr   <= '0;
            fidx   <= '0;
            cidx   <= '0;
            shreg  <= '0;
            flg    <= '0;
            sel    <= '0;
            int_en <= 1'b0;
            irq    <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (act_int_i) int_en <= 1'b1;
            if (abort_i && st != S_IDLE && st != S_STAT) begin
                flg.aborted <= 1'b1;
                st          <= S_STAT;
            end else begin
                case (st)
                    S_IDLE: if (start_i) begin
                        ptr_y <= start_ptr_i[PTR_Y_W-1:0];
                        sel   <= chan_sel_i;
                        flg   <= '{inv_chan: (int'(chan_sel_i) >= NCH), zero_cnt: 1'b0,
                                   aborted: 1'b0, par_err: 1'b0};
                        fidx  <= '0;
                        cidx  <= '0;
                        st    <= S_FETCH;
                    end
                    S_FETCH: if (mem_fire) begin
                        case (fidx)
                            2'd0:    cmd  <= mem_rdata_i[CMD_W-1:0];
                            2'd1:    cnt  <= mem_rdata_i[ADDR_W-1:0];
                            default: addr <= mem_rdata_i[ADDR_W-1:0];
                        endcase
                        fidx <= fidx + 2'd1;
                        if (fidx == 2'd2) st <= flg.inv_chan ? S_STAT : S_CMD;
                    end
                    S_CMD: if (tx_fire) begin
                        cidx <= cidx + 1'b1;
                        if (cidx[0]) begin
                            cidx <= '0;
                            if (cnt == '0) begin
                                flg.zero_cnt <= 1'b1;
                                st           <= S_STAT;
                            end else begin
                                st <= dir_in ? S_RX : S_RDW;
                            end
                        end
                    end
                    S_RDW: if (mem_fire) begin
                        shreg <= mem_rdata_i;
                        st    <= S_TX;
                    end
                    S_TX: if (tx_fire) begin
                        shreg <= shreg << CHAR_W;
                        cidx  <= cidx + 1'b1;
                        if (cidx == CIDX_LAST) begin
                            cidx <= '0;
                            cnt  <= cnt - 1'b1;
                            addr <= addr + 1'b1;
                            st   <= (cnt == ADDR_W'(1)) ? S_STAT : S_RDW;
                        end
                    end
                    S_RX: if (rx_fire) begin
                        shreg <= {shreg[WORD_W-CHAR_W-1:0], rx_char_i};
                        if (rx_perr_i) flg.par_err <= 1'b1;
                        cidx  <= cidx + 1'b1;
                        if (cidx == CIDX_LAST) begin
                            cidx <= '0;
                            st   <= S_WRW;
                        end
                    end
                    S_WRW: if (mem_fire) begin
                        cnt  <= cnt - 1'b1;
                        addr <= addr + 1'b1;
                        st   <= (cnt == ADDR_W'(1)) ? S_STAT : S_RX;
                    end
                    S_STAT: if (mem_fire) begin
                        st  <= S_IDLE;
                        irq <= int_en;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // R1: control-block fetch never writes memory
    a_r1_fetch_reads: assert property (@(posedge clk) disable iff (rst)
        (st == S_FETCH && mem_req_o) |-> !mem_we_o);

    // R7: an ungranted request holds its address and direction
    a_r7_req_held: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_gnt_i && !abort_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R8: an unaccepted character stays offered unchanged
    a_r8_tx_held: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i && !abort_i) |=> (tx_valid_o && $stable(tx_char_o)));

    // R10: busy only drops right after the pointer write was granted
    a_r10_busy_release: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(mem_req_o && mem_gnt_i && mem_we_o && mem_addr_o == PTR_ADDR));

    // R10: the interrupt pulse only appears once the block is idle
    a_r10_irq_idle: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !busy_o);
endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
    import xfer_pkg::*;
#(
    parameter int                NCH      = 4,
    parameter logic [ADDR_W-1:0] PTR_ADDR = 16'h0019
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [WORD_W-1:0]     start_ptr_i,
    input  logic [SEL_W-1:0]      chan_sel_i,
    input  logic                  abort_i,
    input  logic                  act_int_i,
    output logic                  busy_o,
    output logic                  irq_o,
    output logic                  mem_req_o,
    output logic                  mem_we_o,
    output logic [ADDR_W-1:0]     mem_addr_o,
    output logic [WORD_W-1:0]     mem_wdata_o,
    input  logic                  mem_gnt_i,
    input  logic [WORD_W-1:0]     mem_rdata_i,
    output logic [NCH-1:0]        tx_valid_o,
    output logic [NCH*CHAR_W-1:0] tx_char_o,
    output logic [NCH-1:0]        tx_par_o,
    input  logic [NCH-1:0]        tx_ready_i,
    input  logic [NCH-1:0]        rx_valid_i,
    input  logic [NCH*CHAR_W-1:0] rx_char_i,
    input  logic [NCH-1:0]        rx_par_i,
    output logic [NCH-1:0]        rx_ready_o
);
    logic [SEL_W-1:0]  sel;
    logic              chan_en, tx_valid, tx_ready, rx_valid, rx_ready, rx_perr;
    logic [CHAR_W-1:0] tx_char, rx_char;

    xfer_seq #(.NCH(NCH), .PTR_ADDR(PTR_ADDR)) seq_i (
        .clk, .rst, .start_i, .start_ptr_i, .chan_sel_i, .abort_i, .act_int_i,
        .busy_o, .irq_o, .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
        .mem_gnt_i, .mem_rdata_i,
        .sel_o(sel), .chan_en_o(chan_en),
        .tx_valid_o(tx_valid), .tx_char_o(tx_char), .tx_ready_i(tx_ready),
        .rx_valid_i(rx_valid), .rx_char_i(rx_char), .rx_perr_i(rx_perr),
        .rx_ready_o(rx_ready)
    );

    xfer_chan_mux #(.NCH(NCH)) mux_i (
        .clk, .rst, .sel_i(sel), .en_i(chan_en),
        .tx_valid_i(tx_valid), .tx_char_i(tx_char), .tx_ready_o(tx_ready),
        .rx_ready_i(rx_ready), .rx_valid_o(rx_valid), .rx_char_o(rx_char),
        .rx_perr_o(rx_perr),
        .ch_tx_valid_o(tx_valid_o), .ch_tx_char_o(tx_char_o), .ch_tx_par_o(tx_par_o),
        .ch_tx_ready_i(tx_ready_i), .ch_rx_valid_i(rx_valid_i), .ch_rx_char_i(rx_char_i),
        .ch_rx_par_i(rx_par_i), .ch_rx_ready_o(rx_ready_o)
    );
endmodule

// File: tb/xfer_ctrl_tb_top.sv
module xfer_ctrl_tb_top;
    localparam int          NCH = 3;
    localparam logic [15:0] PTR = 16'h001A;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 1'b0, abort = 1'b0, act_int = 1'b0;
    logic [23:0] ptr = '0;
    logic [1:0]  csel = '0;
    logic busy, irq, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [23:0] mem_wdata, mem_rdata;
    logic mem_gnt = 1'b0;
    logic [NCH-1:0]   tx_valid, tx_par, rx_ready;
    logic [NCH*6-1:0] tx_char;
    logic [NCH-1:0]   tx_ready = '0, rx_valid = '0, rx_par = '0;
    logic [NCH*6-1:0] rx_char = '0;

    xfer_ctrl #(.NCH(NCH), .PTR_ADDR(PTR)) dut_i (
        .clk, .rst, .start_i(start), .start_ptr_i(ptr), .chan_sel_i(csel),
        .abort_i(abort), .act_int_i(act_int), .busy_o(busy), .irq_o(irq),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
        .tx_valid_o(tx_valid), .tx_char_o(tx_char), .tx_par_o(tx_par),
        .tx_ready_i(tx_ready), .rx_valid_i(rx_valid), .rx_char_i(rx_char),
        .rx_par_i(rx_par), .rx_ready_o(rx_ready)
    );

    always #10 clk = ~clk;

    logic [23:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_req && mem_gnt && mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    int chk_cnt = 0, fail_cnt = 0, cyc = 0, irq_cnt = 0;
    int log_n = 0;
    int log_ch [0:255];
    logic [5:0] log_c [0:255];
    logic log_pok [0:255];
    logic [5:0] src_c [0:63];
    int src_ch = 0, src_n = 0, src_i = 0, src_bad = -1;
    logic [15:0] lfsr = 16'hACE1;

    // memory grant and channel stalls, plus receive source, driven away from the edge
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_gnt  = mem_req && (lfsr[1:0] != 2'b00);
        tx_ready = {NCH{lfsr[2] | lfsr[3]}};
        for (int c = 0; c < NCH; c++) begin
            rx_valid[c] = (c == src_ch) && (src_i < src_n) && lfsr[4];
            rx_char[c*6 +: 6] = src_c[src_i[5:0]];
            rx_par[c] = ~(^src_c[src_i[5:0]]) ^ (src_i == src_bad);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (irq) irq_cnt++;
        for (int c = 0; c < NCH; c++) begin
            if (tx_valid[c] && tx_ready[c] && log_n < 256) begin
                log_ch[log_n]  = c;
                log_c[log_n]   = tx_char[c*6 +: 6];
                log_pok[log_n] = ^{tx_char[c*6 +: 6], tx_par[c]};
                log_n++;
            end
        end
        if (src_ch < NCH && rx_valid[src_ch] && rx_ready[src_ch]) src_i++;
        if (cyc > 150000) begin
            fail_cnt++;
            $display("FAIL R10 watchdog expired: actual=%0d expected<%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        chk_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] word_pat(input int w, input int seed);
        return 24'(w * 24'h3A5C1 + seed * 24'h1F0F3 + 24'h123456);
    endfunction

    // one complete operation with its checks
    task automatic run_op(input int ch, input logic [11:0] y, input logic [5:0] dev,
                          input logic [5:0] op, input int count, input logic [15:0] addr,
                          input int bad, input int abort_at, input bit exp_irq,
                          input bit poke, input int seed);
        bit dir_in = op[5];
        bit valid  = (ch < NCH);
        int base_irq;
        logic [11:0] exp_st;
        bit done = 0;
        mem[y]        = {12'hABC, dev, op};
        mem[y + 12'd1] = {8'h5A, 16'(count)};
        mem[y + 12'd2] = {8'hC3, addr};
        mem[PTR[7:0]] = 24'h0;
        for (int w = 0; w < count; w++) mem[8'(addr + 16'(w))] = dir_in ? 24'h0 : word_pat(w, seed);
        for (int k = 0; k < 64; k++) src_c[k] = 6'(k * 7 + seed);
        src_i = 0; src_ch = ch; src_bad = bad;
        src_n = (valid && dir_in) ? count * 4 : 0;
        log_n = 0;
        base_irq = irq_cnt;
        @(negedge clk);
        start = 1'b1; ptr = {12'hFFF, y}; csel = 2'(ch);
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            if (abort) abort = 1'b0;
            else if (abort_at >= 0 && !done && ((dir_in ? src_i : log_n) >= abort_at)) begin
                abort = 1'b1; done = 1;
            end
            start = poke && (k == 3);
            if (start) begin ptr = {12'h000, y + 12'h020}; csel = 2'((ch + 1) % NCH); end
            if (!busy) break;
        end
        abort = 1'b0; start = 1'b0;
        @(negedge clk); @(negedge clk);
        exp_st = {8'h0, !valid, valid && count == 0 && abort_at < 0, abort_at >= 0,
                  valid && dir_in && bad >= 0 && abort_at < 0};
        chk(!busy, "R10 busy released", 32'(busy), 0);
        chk(irq_cnt - base_irq == int'(exp_irq), "R10/R11 irq pulses", irq_cnt - base_irq, 32'(exp_irq));
        chk(mem[PTR[7:0]] == {exp_st, y}, "R9 pointer status", mem[PTR[7:0]], {exp_st, y});
        if (!valid) begin
            chk(log_n == 0 && src_i == 0, "R8 invalid channel moves nothing", log_n, 0);
        end else begin
            chk(log_n >= 2 && log_c[0] == dev && log_c[1] == op, "R2 device then opcode",
                {log_c[0], log_c[1]}, {dev, op});
            for (int i = 0; i < log_n; i++) begin
                chk(log_ch[i] == ch, "R8 channel used", log_ch[i], ch);
                chk(log_pok[i], "R6 odd parity on tx", 32'(log_pok[i]), 1);
            end
            if (abort_at >= 0) begin
                chk(dir_in ? (src_i < count * 4) : (log_n < 2 + count * 4), "R12 abort cut short",
                    dir_in ? src_i : log_n, count * 4);
            end else if (!dir_in) begin
                chk(log_n == 2 + count * 4, "R4/R13 output char count", log_n, 2 + count * 4);
                for (int w = 0; w < count; w++)
                    for (int j = 0; j < 4; j++)
                        chk(log_c[2 + w*4 + j] == word_pat(w, seed)[23 - 6*j -: 6], "R4 char order",
                            log_c[2 + w*4 + j], word_pat(w, seed)[23 - 6*j -: 6]);
            end else begin
                chk(log_n == 2, "R5/R13 input sends command only", log_n, 2);
                for (int w = 0; w < count; w++)
                    chk(mem[8'(addr + 16'(w))] == {src_c[w*4], src_c[w*4+1], src_c[w*4+2], src_c[w*4+3]},
                        "R5/R3 packed input word", mem[8'(addr + 16'(w))],
                        {src_c[w*4], src_c[w*4+1], src_c[w*4+2], src_c[w*4+3]});
            end
        end
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(!busy && log_n == 2 + count * 4, "R14 second start ignored", log_n, 2 + count * 4);
        end
        src_n = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 24'h0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !irq && !mem_req, "R10 reset idle", {busy, irq, mem_req}, 0);
        chk(tx_valid == '0 && rx_ready == '0, "R8 reset channels quiet", {tx_valid, rx_ready}, 0);
        // R11: interrupt not yet enabled
        run_op(0, 12'h040, 6'd9, 6'd1, 1, 16'h0080, -1, -1, 0, 0, 1);
        @(negedge clk); act_int = 1'b1; @(negedge clk); act_int = 1'b0;
        // R12: abort while idle is ignored
        abort = 1'b1; @(negedge clk); abort = 1'b0;
        chk(!busy, "R12 idle abort no start", 32'(busy), 0);
        for (int ch = 0; ch < NCH; ch++)
            for (int d = 0; d < 2; d++)
                for (int n = 0; n < 4; n++)
                    run_op(ch, 12'h044 + 12'(ch*4), 6'(10 + ch), {d[0], 5'(n + ch)}, n,
                           16'h0090 + 16'(ch*8), -1, -1, 1, 0, ch*8 + d*4 + n);
        run_op(3, 12'h050, 6'd3, 6'd2, 2, 16'h00A0, -1, -1, 1, 0, 40);      // R8 invalid select
        run_op(1, 12'h054, 6'd4, 6'h21, 2, 16'h00B0, 5, -1, 1, 0, 41);      // R6 receive parity error
        run_op(2, 12'h058, 6'd5, 6'h03, 5, 16'h00C0, -1, 6, 1, 0, 42);      // R12 abort on output
        run_op(0, 12'h05C, 6'd6, 6'h24, 5, 16'h00D0, -1, 3, 1, 0, 43);      // R12 abort on input
        run_op(1, 12'h060, 6'd7, 6'h05, 2, 16'h00E0, -1, -1, 1, 1, 44);     // R14 start while busy
        finish_run();
    end
endmodule